// File: doc/BRIEF.md
# Two-Channel Indexed Register Port with Reference-Clock Counter

This block is the byte-wide host register port of a two-channel disk controller. Each channel owns an eight-byte I/O window. Inside a window, byte offset 1 holds an index and byte offset 3 is a data port. The host first writes a register number to offset 1. A later read or write at offset 3 then reaches the register that the index selects. The secondary window sits eight bytes above the primary one, and each window keeps its own index.

Behind the windows sit several registers. Each channel has a control byte, and bit 6 of the primary control byte starts and stops a 30-bit down counter. That counter is stepped by a reference-clock tick and is used to measure the frequency of that clock. Its value is exposed as four overlapping byte slices, split across the two windows. The secondary window also holds two PLL settings, a feedback value F and an input divider R. Each channel has a read-only cable-type bit and sixteen drive timing bytes, covering two drives of eight bytes each.

The PLL settings and the timing bytes are only stored and driven out to the logic that uses them. The counter slices are taken live from the counter, so a host that reads the four pieces while the counter runs can observe a torn value.

Top module: `idxwin_top`

## Requirements
- R1: After reset, both index registers, both control bytes, F, R and all timing bytes read 0x00, and the counter holds CNT_INIT (default 0x3FFFFFFF).
- R2: A write to host address 1 (primary) or 9 (secondary) loads that window's index, and a read there returns it. The two indexes are independent. Address 3 or 11 reads or writes the register that its own window's index selects.
- R3: Index 0x01 in either window is an 8-bit control byte that reads back exactly what was written.
- R4: The counter decrements by one on each clock that has ref_tick high while bit 6 of the primary control byte is 1. Otherwise it holds its value, whatever the secondary control byte contains.
- R5: The counter wraps from 0 to 0x3FFFFFFF, so it counts modulo 2^30.
- R6: Reads of the counter slices use the live counter value C. Primary index 0x20 reads C[7:0] and primary 0x21 reads C[15:8]. Secondary 0x20 reads C[22:15] and secondary 0x21 reads {0, C[29:23]}. The host rebuilds C as s3<<23 | s2<<15 | s1<<8 | s0.
- R7: Secondary index 0x02 holds F as 7 bits: bit 7 of a write is dropped and reads as 0. Secondary index 0x03 holds R as 8 bits. Both appear at pll_fb and pll_div.
- R8: Index 0x0b in each window reads cable_40 of that channel in bit 2, with every other bit 0. Writes to 0x0b have no effect.
- R9: Indexes 0x0c to 0x1b in each window are timing bytes. Drive 0 uses 0x0c to 0x13 and drive 1 uses 0x14 to 0x1b. Channel c, index i appears at drv_timing[(c*16 + i - 0x0c)*8 +: 8].
- R10: Writes to indexes with no writable register are ignored, and they read 0x00 unless R6 or R8 gives a value. This covers primary 0x02 and 0x03, both counter slice indexes, and any index outside those listed.
- R11: Host addresses other than 1, 3, 9 and 11 read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 4 | Byte address: bit 3 picks the window, bits 2:0 the offset |
| host_wr | input | 1 | Write strobe for host_wdata at host_addr |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr, combinational |
| ref_tick | input | 1 | One pulse per reference-clock cycle, synchronous to clk |
| cable_40 | input | 2 | Per channel: 1 = 40-conductor cable |
| pll_fb | output | 7 | PLL feedback value F |
| pll_div | output | 8 | PLL input divider R |
| drv_timing | output | 256 | All timing bytes, per the R9 layout |

## Verification
A wrong run condition or a wrong wrap shows as a counter slice that differs from the reference count on the very next clock. Because the slices are read combinationally, the mismatch appears at host_rdata as soon as a slice index is selected. A control, index or timing byte that takes an ignored write, or misses a real one, shows at drv_timing, pll_fb or pll_div on the clock after the write. Tearing is not flagged as an error: each slice must match the live count at the moment it is read, and that also holds while the counter runs.

// File: rtl/idxwin_pkg.sv
package idxwin_pkg;
   localparam int BYTE_W      = 8;
   localparam int OFS_W       = 3;
   localparam logic [OFS_W-1:0] OFS_INDEX = 3'd1;
   localparam logic [OFS_W-1:0] OFS_DATA  = 3'd3;

   localparam logic [7:0] IX_CTRL   = 8'h01;
   localparam logic [7:0] IX_PLL_F  = 8'h02;
   localparam logic [7:0] IX_PLL_R  = 8'h03;
   localparam logic [7:0] IX_CABLE  = 8'h0b;
   localparam logic [7:0] IX_TIM    = 8'h0c;
   localparam logic [7:0] IX_SLC_LO = 8'h20;
   localparam logic [7:0] IX_SLC_HI = 8'h21;

   localparam int RUN_BIT       = 6;
   localparam int CABLE_BIT     = 2;
   localparam int TIM_PER_DRIVE = 8;
   localparam int DRIVES        = 2;

   // Low bit positions of the four counter slices (fixed by host software)
   localparam int SLC0_LO = 0;
   localparam int SLC1_LO = 8;
   localparam int SLC2_LO = 15;
   localparam int SLC3_LO = 23;
endpackage

// File: rtl/idxwin_meas_cnt.sv
module idxwin_meas_cnt #(
   parameter int CNT_W = 30,
   parameter logic [CNT_W-1:0] CNT_INIT = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             tick_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   if (CNT_W < 2) begin : g_bad_w
      $error("idxwin_meas_cnt: CNT_W too small");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             step;

   assign step = run_i & tick_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= CNT_INIT;
      else if (step) cnt_q <= cnt_q - 1'b1;
   end

   assign cnt_o = cnt_q;

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(cnt_o));
   p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cnt_o == '0) |=> (cnt_o == CNT_TOP));
endmodule

// File: rtl/idxwin_pll_regs.sv
module idxwin_pll_regs #(
   parameter int F_W = 7,
   parameter int R_W = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           we_f,
   input  logic           we_r,
   input  logic [7:0]     wdata,
   output logic [F_W-1:0] f_o,
   output logic [R_W-1:0] r_o
);
   if (F_W > 8 || R_W > 8 || F_W < 1 || R_W < 1) begin : g_bad_w
      $error("idxwin_pll_regs: field widths must be 1..8");
   end

   logic [F_W-1:0] f_q;
   logic [R_W-1:0] r_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_q <= '0;
         r_q <= '0;
      end else begin
         if (we_f) f_q <= wdata[F_W-1:0];
         if (we_r) r_q <= wdata[R_W-1:0];
      end
   end

   assign f_o = f_q;
   assign r_o = r_q;

   p_pll_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(we_f || we_r) |=> $stable({f_o, r_o}));
endmodule

// File: rtl/idxwin_chan.sv
module idxwin_chan
   import idxwin_pkg::*;
#(
   parameter int TIM_N = DRIVES * TIM_PER_DRIVE
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                idx_we,
   input  logic                data_we,
   input  logic [7:0]          wdata,
   input  logic                cable_i,
   output logic [7:0]          idx_o,
   output logic                run_o,
   output logic [7:0]          rd_o,
   output logic [TIM_N*8-1:0]  timing_o
);
   localparam int TIM_AW = (TIM_N > 1) ? $clog2(TIM_N) : 1;
   localparam logic [7:0] IX_TIM_END = IX_TIM + 8'(TIM_N);

   if (TIM_N < 1 || IX_TIM + TIM_N > 256) begin : g_bad_tim
      $error("idxwin_chan: timing range does not fit the index space");
   end

   logic [7:0]        idx_q;
   logic [7:0]        ctrl_q;
   logic [7:0]        tim_q [TIM_N];
   logic              tim_hit;
   logic [7:0]        tim_ofs8;
   logic [TIM_AW-1:0] tim_ofs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idx_q <= '0;
      else if (idx_we) idx_q <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             ctrl_q <= '0;
      else if (data_we && idx_q == IX_CTRL)   ctrl_q <= wdata;
   end

   assign tim_hit  = (idx_q >= IX_TIM) && (idx_q < IX_TIM_END);
   assign tim_ofs8 = idx_q - IX_TIM;
   assign tim_ofs  = tim_ofs8[TIM_AW-1:0];

   for (genvar g = 0; g < TIM_N; g++) begin : g_tim
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            tim_q[g] <= '0;
         else if (data_we && tim_hit && tim_ofs == TIM_AW'(g))
            tim_q[g] <= wdata;
      end
      assign timing_o[g*8 +: 8] = tim_q[g];
   end

   always_comb begin
      rd_o = '0;
      if (idx_q == IX_CTRL)
         rd_o = ctrl_q;
      else if (idx_q == IX_CABLE)
         rd_o[CABLE_BIT] = cable_i;
      else if (tim_hit)
         rd_o = tim_q[tim_ofs];
   end

   assign idx_o = idx_q;
   assign run_o = ctrl_q[RUN_BIT];

   p_idx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !idx_we |=> $stable(idx_o));
   p_ctrl_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (data_we && idx_o != IX_CTRL) |=> $stable(run_o));
   p_tim_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !data_we |=> $stable(timing_o));
   p_tim_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (data_we && idx_o == IX_CABLE) |=> $stable(timing_o));
endmodule

// File: rtl/idxwin_top.sv
module idxwin_top
   import idxwin_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int CNT_W  = 30,
   parameter logic [CNT_W-1:0] CNT_INIT = '1,
   parameter int RUN_CH = 0,
   parameter int PLL_CH = 1,
   parameter int F_W    = 7,
   parameter int R_W    = 8,
   parameter int TIM_N  = DRIVES * TIM_PER_DRIVE
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [$clog2(NUM_CH)+2:0]  host_addr,
   input  logic                       host_wr,
   input  logic [7:0]                 host_wdata,
   output logic [7:0]                 host_rdata,
   input  logic                       ref_tick,
   input  logic [NUM_CH-1:0]          cable_40,
   output logic [F_W-1:0]             pll_fb,
   output logic [R_W-1:0]             pll_div,
   output logic [NUM_CH*TIM_N*8-1:0]  drv_timing
);
   localparam int CH_W = $clog2(NUM_CH);
   localparam logic [NUM_CH-1:0] RUN_SEL = NUM_CH'(1) << RUN_CH;

   if (NUM_CH != 2) begin : g_bad_ch
      $error("idxwin_top: counter slices are laid out for two windows");
   end
   if (CNT_W != 30) begin : g_bad_cnt
      $error("idxwin_top: slice positions assume a 30-bit counter");
   end
   if (RUN_CH >= NUM_CH || PLL_CH >= NUM_CH) begin : g_bad_sel
      $error("idxwin_top: RUN_CH or PLL_CH out of range");
   end

   logic [CH_W-1:0]   ch;
   logic [OFS_W-1:0]  ofs;
   logic [7:0]        ch_idx   [NUM_CH];
   logic [7:0]        ch_rd    [NUM_CH];
   logic [7:0]        slc_lo   [NUM_CH];
   logic [7:0]        slc_hi   [NUM_CH];
   logic [NUM_CH-1:0] ch_run;
   logic [NUM_CH-1:0] idx_we;
   logic [NUM_CH-1:0] data_we;
   logic [CNT_W-1:0]  cnt;
   logic              test_run;
   logic [7:0]        sel_idx;
   logic [7:0]        pll_part;
   logic [7:0]        slc_part;
   logic              pll_ch_sel;

   assign ch  = host_addr[OFS_W +: CH_W];
   assign ofs = host_addr[OFS_W-1:0];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign idx_we[c]  = host_wr && (ch == CH_W'(c)) && (ofs == OFS_INDEX);
      assign data_we[c] = host_wr && (ch == CH_W'(c)) && (ofs == OFS_DATA);

      idxwin_chan #(.TIM_N(TIM_N)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .idx_we   (idx_we[c]),
         .data_we  (data_we[c]),
         .wdata    (host_wdata),
         .cable_i  (cable_40[c]),
         .idx_o    (ch_idx[c]),
         .run_o    (ch_run[c]),
         .rd_o     (ch_rd[c]),
         .timing_o (drv_timing[c*TIM_N*8 +: TIM_N*8])
      );

      if (c == 0) begin : g_slc_low
         assign slc_lo[c] = cnt[SLC0_LO +: 8];
         assign slc_hi[c] = cnt[SLC1_LO +: 8];
      end else begin : g_slc_high
         assign slc_lo[c] = cnt[SLC2_LO +: 8];
         assign slc_hi[c] = {1'b0, cnt[CNT_W-1:SLC3_LO]};
      end
   end

   assign test_run = |(ch_run & RUN_SEL);

   idxwin_meas_cnt #(.CNT_W(CNT_W), .CNT_INIT(CNT_INIT)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (test_run),
      .tick_i (ref_tick),
      .cnt_o  (cnt)
   );

   idxwin_pll_regs #(.F_W(F_W), .R_W(R_W)) u_pll (
      .clk   (clk),
      .rst_n (rst_n),
      .we_f  (data_we[PLL_CH] && ch_idx[PLL_CH] == IX_PLL_F),
      .we_r  (data_we[PLL_CH] && ch_idx[PLL_CH] == IX_PLL_R),
      .wdata (host_wdata),
      .f_o   (pll_fb),
      .r_o   (pll_div)
   );

   assign sel_idx    = ch_idx[ch];
   assign pll_ch_sel = (ch == CH_W'(PLL_CH));

   always_comb begin
      pll_part = '0;
      if (pll_ch_sel && sel_idx == IX_PLL_F) pll_part = 8'(pll_fb);
      else if (pll_ch_sel && sel_idx == IX_PLL_R) pll_part = 8'(pll_div);
   end

   always_comb begin
      slc_part = '0;
      if (sel_idx == IX_SLC_LO)      slc_part = slc_lo[ch];
      else if (sel_idx == IX_SLC_HI) slc_part = slc_hi[ch];
   end

   always_comb begin
      case (ofs)
         OFS_INDEX: host_rdata = sel_idx;
         OFS_DATA:  host_rdata = ch_rd[ch] | pll_part | slc_part;
         default:   host_rdata = '0;
      endcase
   end

   p_slice_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_wr && ofs == OFS_DATA && sel_idx == IX_SLC_LO && ch == '0 && !(test_run && ref_tick))
      |=> (ofs != OFS_DATA || sel_idx != IX_SLC_LO || ch != '0 || $stable(host_rdata)));
   p_offset_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && ofs != OFS_INDEX && ofs != OFS_DATA) |=> $stable(drv_timing));
endmodule

// File: tb/test_idxwin_top.sv
module test_idxwin_top;
   localparam logic [29:0] INIT = 30'h0000_8002;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [3:0]   host_addr = '0;
   logic         host_wr = 1'b0;
   logic [7:0]   host_wdata = '0;
   logic [7:0]   host_rdata;
   logic         ref_tick = 1'b0;
   logic [1:0]   cable_40 = '0;
   logic [6:0]   pll_fb;
   logic [7:0]   pll_div;
   logic [255:0] drv_timing;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   idxwin_top #(.CNT_INIT(INIT)) i_idxwin_top (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .ref_tick(ref_tick),
      .cable_40(cable_40), .pll_fb(pll_fb), .pll_div(pll_div),
      .drv_timing(drv_timing));

   // ---------------- behavioural reference model ----------------
   logic [29:0] m_cnt;
   logic [7:0]  m_idx [2];
   logic [7:0]  m_ctl [2];
   logic [7:0]  m_tim [2][16];
   logic [6:0]  m_f;
   logic [7:0]  m_r;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt <= INIT;
         m_f <= '0;
         m_r <= '0;
         for (int c = 0; c < 2; c++) begin
            m_idx[c] <= '0;
            m_ctl[c] <= '0;
            for (int t = 0; t < 16; t++) m_tim[c][t] <= '0;
         end
      end else begin
         if (ref_tick && m_ctl[0][6]) m_cnt <= m_cnt - 30'd1;
         if (host_wr) begin
            automatic int c = host_addr[3];
            automatic int i = m_idx[c];
            if (host_addr[2:0] == 3'd1) m_idx[c] <= host_wdata;
            else if (host_addr[2:0] == 3'd3) begin
               if (i == 1) m_ctl[c] <= host_wdata;
               else if (c == 1 && i == 2) m_f <= host_wdata[6:0];
               else if (c == 1 && i == 3) m_r <= host_wdata;
               else if (i >= 12 && i < 28) m_tim[c][i-12] <= host_wdata;
            end
         end
      end
   end

   function automatic logic [7:0] exp_rd();
      int c = host_addr[3];
      int i = m_idx[c];
      logic [7:0] v = '0;
      if (host_addr[2:0] == 3'd1) return m_idx[c];
      if (host_addr[2:0] != 3'd3) return 8'h00;
      if (i == 1) v = m_ctl[c];
      else if (i == 11) v = {5'b0, cable_40[c], 2'b0};
      else if (i >= 12 && i < 28) v = m_tim[c][i-12];
      else if (c == 1 && i == 2) v = {1'b0, m_f};
      else if (c == 1 && i == 3) v = m_r;
      else if (i == 32) v = (c == 0) ? m_cnt[7:0] : m_cnt[22:15];
      else if (i == 33) v = (c == 0) ? m_cnt[15:8] : {1'b0, m_cnt[29:23]};
      return v;
   endfunction

   function automatic logic [255:0] exp_tim();
      logic [255:0] v;
      for (int c = 0; c < 2; c++)
         for (int t = 0; t < 16; t++) v[(c*16+t)*8 +: 8] = m_tim[c][t];
      return v;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // every-clock comparison against the model (R2 R6 R7 R9 R11)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(host_rdata === exp_rd(), "R6 model rdata", 64'(host_rdata), 64'(exp_rd()));
         check(pll_fb === m_f && pll_div === m_r, "R7 model pll",
               {49'b0, pll_fb, pll_div}, {49'b0, m_f, m_r});
         check(drv_timing === exp_tim(), "R9 model timing",
               drv_timing[63:0], exp_tim() ^ 256'(0) >> 0);
      end
   end

   // ---------------- host tasks ----------------
   task automatic hwrite(input logic [3:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      host_addr = a; host_wr = 1'b1; host_wdata = d;
      @(posedge clk); #1;
      host_wr = 1'b0;
   endtask

   task automatic wreg(input int c, input logic [7:0] i, input logic [7:0] d);
      hwrite(4'(c*8 + 1), i);
      hwrite(4'(c*8 + 3), d);
   endtask

   task automatic rreg(input int c, input logic [7:0] i, output logic [7:0] d);
      hwrite(4'(c*8 + 1), i);
      host_addr = 4'(c*8 + 3);
      @(negedge clk);
      d = host_rdata;
   endtask

   task automatic rd_count(output logic [29:0] v);
      logic [7:0] s0, s1, s2, s3;
      rreg(0, 8'h20, s0);
      rreg(0, 8'h21, s1);
      rreg(1, 8'h20, s2);
      rreg(1, 8'h21, s3);
      v = 30'((int'(s3) << 23) | (int'(s2) << 15) | (int'(s1) << 8) | int'(s0));
   endtask

   task automatic ticks(input int n);
      @(posedge clk); #1;
      ref_tick = 1'b1;
      repeat (n) @(posedge clk);
      #1 ref_tick = 1'b0;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #900000;
      if (!done) begin
         done = 1'b1;
         failures++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   // ---------------- directed sequence ----------------
   initial begin
      logic [7:0]  d;
      logic [29:0] v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      check(host_rdata == 8'h00 && pll_fb == 0 && pll_div == 0 && drv_timing == '0,
            "R1 reset outputs", 64'(host_rdata), 64'h0);
      rd_count(v);
      check(v == INIT, "R1 reset count", 64'(v), 64'(INIT));
      rreg(0, 8'h01, d);
      check(d == 8'h00, "R1 reset ctrl", 64'(d), 64'h0);

      // R2 index readback and independence
      hwrite(4'd1, 8'h0c);
      hwrite(4'd9, 8'h14);
      host_addr = 4'd1; @(negedge clk);
      check(host_rdata == 8'h0c, "R2 primary index", 64'(host_rdata), 64'h0c);
      host_addr = 4'd9; @(negedge clk);
      check(host_rdata == 8'h14, "R2 secondary index", 64'(host_rdata), 64'h14);

      // R3 control bytes, bit 6 clear so nothing runs
      wreg(0, 8'h01, 8'ha5);
      wreg(1, 8'h01, 8'hff);
      rreg(0, 8'h01, d);
      check(d == 8'ha5, "R3 primary ctrl", 64'(d), 64'ha5);
      rreg(1, 8'h01, d);
      check(d == 8'hff, "R3 secondary ctrl", 64'(d), 64'hff);

      // R4 secondary run bit has no effect
      ticks(10);
      rd_count(v);
      check(v == INIT, "R4 hold with primary bit6 clear", 64'(v), 64'(INIT));

      // R4 run via read-modify-write of primary ctrl
      rreg(0, 8'h01, d);
      wreg(0, 8'h01, d | 8'h40);
      ticks(5);
      wreg(0, 8'h01, (d | 8'h40) & ~8'h40);
      rd_count(v);
      check(v == INIT - 30'd5, "R4 five decrements", 64'(v), 64'(INIT - 30'd5));
      rreg(0, 8'h01, d);
      check(d == 8'ha5, "R4 other ctrl bits kept", 64'(d), 64'ha5);
      ticks(7);
      rd_count(v);
      check(v == INIT - 30'd5, "R4 hold after stop", 64'(v), 64'(INIT - 30'd5));

      // R5 wrap through zero
      wreg(0, 8'h01, 8'h40);
      ticks(int'(INIT) - 5 + 1);
      wreg(0, 8'h01, 8'h00);
      rd_count(v);
      check(v == 30'h3fff_ffff, "R5 wrap to all ones", 64'(v), 64'h3fffffff);

      // R6 live slice while running (each cycle also compared to the model)
      rreg(1, 8'h21, d);
      check(d == 8'h7f, "R6 top slice", 64'(d), 64'h7f);
      wreg(0, 8'h01, 8'h40);
      hwrite(4'd1, 8'h20);
      host_addr = 4'd3;
      ref_tick = 1'b1;
      repeat (20) @(negedge clk);
      #1 ref_tick = 1'b0;
      wreg(0, 8'h01, 8'h00);

      // R7 PLL fields
      wreg(1, 8'h02, 8'hff);
      wreg(1, 8'h03, 8'h0d);
      rreg(1, 8'h02, d);
      check(d == 8'h7f && pll_fb == 7'h7f, "R7 F seven bits", 64'(d), 64'h7f);
      rreg(1, 8'h03, d);
      check(d == 8'h0d && pll_div == 8'h0d, "R7 R byte", 64'(d), 64'h0d);

      // R10 primary 0x02 and counter slice writes ignored
      wreg(0, 8'h02, 8'h55);
      rreg(0, 8'h02, d);
      check(d == 8'h00 && pll_fb == 7'h7f, "R10 primary pll index", 64'(d), 64'h0);
      rd_count(v);
      wreg(0, 8'h20, 8'h00);
      wreg(1, 8'h21, 8'h00);
      begin
         logic [29:0] v2;
         rd_count(v2);
         check(v2 == v, "R10 slice write ignored", 64'(v2), 64'(v));
      end
      wreg(0, 8'h30, 8'h77);
      rreg(0, 8'h30, d);
      check(d == 8'h00, "R10 unused index", 64'(d), 64'h0);

      // R8 cable bit, read only
      cable_40 = 2'b10;
      rreg(1, 8'h0b, d);
      check(d == 8'h04, "R8 secondary cable", 64'(d), 64'h04);
      rreg(0, 8'h0b, d);
      check(d == 8'h00, "R8 primary cable", 64'(d), 64'h00);
      wreg(0, 8'h0b, 8'hff);
      rreg(0, 8'h0b, d);
      check(d == 8'h00 && drv_timing == '0, "R8 write ignored", 64'(d), 64'h0);

      // R9 timing bytes, both drives and both windows
      wreg(0, 8'h0c, 8'h27);
      wreg(0, 8'h1b, 8'hcb);
      wreg(1, 8'h14, 8'h1a);
      check(drv_timing[7:0] == 8'h27, "R9 ch0 drive0 first", 64'(drv_timing[7:0]), 64'h27);
      check(drv_timing[15*8 +: 8] == 8'hcb, "R9 ch0 drive1 last", 64'(drv_timing[15*8 +: 8]), 64'hcb);
      check(drv_timing[24*8 +: 8] == 8'h1a, "R9 ch1 drive1 first", 64'(drv_timing[24*8 +: 8]), 64'h1a);
      rreg(1, 8'h14, d);
      check(d == 8'h1a, "R9 readback", 64'(d), 64'h1a);

      // R11 other offsets
      hwrite(4'd5, 8'hee);
      hwrite(4'd8, 8'hee);
      host_addr = 4'd0; @(negedge clk);
      check(host_rdata == 8'h00, "R11 offset 0", 64'(host_rdata), 64'h0);
      host_addr = 4'd13; @(negedge clk);
      check(host_rdata == 8'h00, "R11 offset 13", 64'(host_rdata), 64'h0);
      host_addr = 4'd9; @(negedge clk);
      check(host_rdata == 8'h14, "R11 index untouched", 64'(host_rdata), 64'h14);

      repeat (2) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule